// File: doc/BRIEF.md
# Link Receiver Detection Sequencer

This block is the control sequencer that checks whether a far-end receiver is attached to a serial transmit lane. A requester raises a detect request. The lane must be in the low-power state P1 for the check to run. If it is, the sequencer first holds the line driver at its common-mode level for a fixed number of cycles. It then lets the line go, waits a settle interval that software sets, and samples a threshold comparator once. The outcome is reported through a one-cycle completion pulse and a three-bit status code. The analog driver and the comparator sit outside the block and appear here as plain digital ports.

A slow rise on the released line points to the large coupling capacitance of a terminated receiver. The comparator reports this as "below threshold", and that reading counts as a receiver being present. The completion pulse is the same strobe that other PHY operations use, so a request made in the wrong power state still gets an answer. That answer reports no receiver, so the requester never waits forever.

Top module: `rxdet_seq`

## Requirements
- R1: A detection sequence starts only on a rising edge of `det_req` seen while idle with `pwr_state` equal to 2'b01 (P1). `drive_cm` rises in the cycle after that edge is sampled.
- R2: A rising edge of `det_req` seen while idle with `pwr_state` not equal to 2'b01 never raises `drive_cm`. `done_o` is high in the next cycle with status 3'b000.
- R3: `drive_cm` stays high for exactly DRIVE_LEN cycles. It is followed at once by exactly one cycle of `release_o`. At most one of `drive_cm`, `release_o`, `cmp_strobe` and `done_o` is high in any cycle.
- R4: After `release_o`, the block waits N idle cycles before `cmp_strobe`. N is the value of `settle_cnt` captured when the request is accepted, and a captured value of 0 counts as 1. Later changes of `settle_cnt` have no effect on the running sequence.
- R5: `cmp_strobe` is high for one cycle right after the wait. `cmp_below` is sampled only at the end of that cycle, and its value in any other cycle does not affect the result.
- R6: `done_o` is high in the cycle after `cmp_strobe`. `status_o` is 3'b011 if the sampled `cmp_below` was 1 and 3'b000 otherwise. `status_o` is 3'b000 in every cycle where `done_o` is low.
- R7: `done_o` is a single-cycle pulse. Holding `det_req` high after a sequence does not start another one; `det_req` must go low and then high again.
- R8: A synchronous active-high `rst` returns the block to idle. All of `drive_cm`, `release_o`, `cmp_strobe` and `done_o` are low, and `status_o` is 3'b000, in the cycle after reset is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| det_req | input | 1 | Detect request; a rising edge is a request |
| pwr_state | input | 2 | Lane power state; 2'b01 is P1 |
| settle_cnt | input | 16 | Settle interval in cycles, captured at start |
| cmp_below | input | 1 | Comparator: line level below threshold |
| drive_cm | output | 1 | Hold line driver at common-mode level |
| release_o | output | 1 | Release the line driver |
| cmp_strobe | output | 1 | Comparator sampling strobe |
| done_o | output | 1 | One-cycle completion pulse |
| status_o | output | 3 | Result code, valid while done_o is high |

## Verification
A wrong state or a miscounted timer changes when the completion pulse arrives. The scoreboard compares that arrival against a cycle number it computes from the request cycle, the drive length and the effective interval, so such a fault is caught in the very sequence where it happens. A wrong sampling cycle for the comparator shows up in the status code, because the bench drives the inverse value in every cycle except the strobe cycle. A lost edge detection shows up within a few cycles: either a sequence starts with nothing queued in the scoreboard, or an expected completion never arrives.

// File: rtl/rxdet_pkg.sv
package rxdet_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_DRIVE,
    S_RELEASE,
    S_WAIT,
    S_COMPARE,
    S_DONE
  } rxdet_state_t;

  localparam logic [1:0] PS_P1       = 2'b01;
  localparam logic [2:0] STAT_FOUND  = 3'b011;
  localparam logic [2:0] STAT_NONE   = 3'b000;

  function automatic logic [2:0] result_code(input logic below);
    return below ? STAT_FOUND : STAT_NONE;
  endfunction

endpackage

// File: rtl/rxdet_req_edge.sv
module rxdet_req_edge (
  input  logic clk,
  input  logic rst,
  input  logic req,
  output logic rise
);
  logic req_q;

  always_ff @(posedge clk) begin
    if (rst) req_q <= 1'b0;
    else     req_q <= req;
  end

  assign rise = req & ~req_q;
endmodule

// File: rtl/rxdet_interval_timer.sv
module rxdet_interval_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             last
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (load)        cnt <= load_val;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign last = (cnt == {{(CNT_W-1){1'b0}}, 1'b1});

  // R4: a loaded count never starts from zero
  a_r4_load_nonzero: assert property (@(posedge clk) disable iff (rst)
    load |-> (load_val != '0));
endmodule

// File: rtl/rxdet_ctrl.sv
module rxdet_ctrl
  import rxdet_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int DRIVE_LEN = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [1:0]       pwr_state,
  input  logic [CNT_W-1:0] settle_cnt,
  input  logic             cmp_below,
  input  logic             tmr_last,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_val,
  output logic             drive_cm,
  output logic             release_o,
  output logic             cmp_strobe,
  output logic             done_o,
  output logic [2:0]       status_o
);
  localparam logic [CNT_W-1:0] DRIVE_LD = CNT_W'(DRIVE_LEN);

  function automatic logic [CNT_W-1:0] eff_interval(input logic [CNT_W-1:0] v);
    return (v == '0) ? {{(CNT_W-1){1'b0}}, 1'b1} : v;
  endfunction

  rxdet_state_t     state, nxt;
  logic [CNT_W-1:0] settle_q;
  logic             res_q;
  logic             in_p1;
  logic             accept;
  logic             refuse;

  assign in_p1  = (pwr_state == PS_P1);
  assign accept = (state == S_IDLE) && start && in_p1;
  assign refuse = (state == S_IDLE) && start && !in_p1;

  always_comb begin
    nxt      = state;
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (state)
      S_IDLE: begin
        if (accept) begin
          nxt      = S_DRIVE;
          tmr_load = 1'b1;
          tmr_val  = DRIVE_LD;
        end else if (refuse) begin
          nxt = S_DONE;
        end
      end
      S_DRIVE:   if (tmr_last) nxt = S_RELEASE;
      S_RELEASE: begin
        nxt      = S_WAIT;
        tmr_load = 1'b1;
        tmr_val  = eff_interval(settle_q);
      end
      S_WAIT:    if (tmr_last) nxt = S_COMPARE;
      S_COMPARE: nxt = S_DONE;
      S_DONE:    nxt = S_IDLE;
      default:   nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= S_IDLE;
      settle_q <= '0;
      res_q    <= 1'b0;
    end else begin
      state <= nxt;
      if (accept) settle_q <= settle_cnt;
      if (refuse) res_q <= 1'b0;
      else if (state == S_COMPARE) res_q <= cmp_below;
    end
  end

  assign drive_cm   = (state == S_DRIVE);
  assign release_o  = (state == S_RELEASE);
  assign cmp_strobe = (state == S_COMPARE);
  assign done_o     = (state == S_DONE);
  assign status_o   = done_o ? result_code(res_q) : STAT_NONE;

  a_r1_drive_only_from_p1: assert property (@(posedge clk) disable iff (rst)
    $rose(drive_cm) |-> ($past(pwr_state) == PS_P1));

  a_r2_refuse_replies: assert property (@(posedge clk) disable iff (rst)
    refuse |=> (done_o && status_o == STAT_NONE && !drive_cm));

  a_r3_one_phase: assert property (@(posedge clk) disable iff (rst)
    $onehot0({drive_cm, release_o, cmp_strobe, done_o}));

  a_r3_release_follows_drive: assert property (@(posedge clk) disable iff (rst)
    $fell(drive_cm) |-> release_o);

  a_r5_strobe_then_done: assert property (@(posedge clk) disable iff (rst)
    cmp_strobe |=> done_o);

  a_r6_status_gated: assert property (@(posedge clk) disable iff (rst)
    !done_o |-> (status_o == STAT_NONE));

  a_r7_done_single: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  a_r8_reset_quiet: assert property (@(posedge clk)
    rst |=> !(drive_cm || release_o || cmp_strobe || done_o));
endmodule

// File: rtl/rxdet_seq.sv
module rxdet_seq #(
  parameter int CNT_W     = 16,
  parameter int DRIVE_LEN = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             det_req,
  input  logic [1:0]       pwr_state,
  input  logic [CNT_W-1:0] settle_cnt,
  input  logic             cmp_below,
  output logic             drive_cm,
  output logic             release_o,
  output logic             cmp_strobe,
  output logic             done_o,
  output logic [2:0]       status_o
);
  logic             start;
  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic             tmr_last;

  rxdet_req_edge u_edge (
    .clk  (clk),
    .rst  (rst),
    .req  (det_req),
    .rise (start)
  );

  rxdet_interval_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .last     (tmr_last)
  );

  rxdet_ctrl #(.CNT_W(CNT_W), .DRIVE_LEN(DRIVE_LEN)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .pwr_state  (pwr_state),
    .settle_cnt (settle_cnt),
    .cmp_below  (cmp_below),
    .tmr_last   (tmr_last),
    .tmr_load   (tmr_load),
    .tmr_val    (tmr_val),
    .drive_cm   (drive_cm),
    .release_o  (release_o),
    .cmp_strobe (cmp_strobe),
    .done_o     (done_o),
    .status_o   (status_o)
  );
endmodule

// File: tb/rxdet_seq_test.sv
module rxdet_seq_test;
  localparam int DL = 4;
  localparam logic [1:0] P1 = 2'b01;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        det_req = 1'b0;
  logic [1:0]  pwr_state = 2'b00;
  logic [15:0] settle_cnt = 16'd0;
  logic        cmp_below = 1'b0;
  logic        drive_cm, release_o, cmp_strobe, done_o;
  logic [2:0]  status_o;

  always #4 clk = ~clk;

  rxdet_seq #(.CNT_W(16), .DRIVE_LEN(DL)) uut (
    .clk(clk), .rst(rst), .det_req(det_req), .pwr_state(pwr_state),
    .settle_cnt(settle_cnt), .cmp_below(cmp_below), .drive_cm(drive_cm),
    .release_o(release_o), .cmp_strobe(cmp_strobe), .done_o(done_o),
    .status_o(status_o)
  );

  typedef struct {
    int unsigned at;
    logic [2:0]  code;
    string       tag;
  } exp_t;

  exp_t        q[$];
  exp_t        e;
  int          checks = 0;
  int          fails = 0;
  int unsigned cyc = 0;
  bit          exp_cmp = 1'b0;
  int          exp_n = 1;
  int          drv_run = 0;
  int          wait_run = 0;
  bit          in_wait = 1'b0;
  bit          rej_mode = 1'b0;
  bit          quiet = 1'b0;
  bit          finished = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, expv);
    end
  endtask

  // Monitor: pops expected results and checks sequence timing
  always @(negedge clk) begin
    if (!rst) begin
      if (drive_cm) begin
        drv_run++;
        chk(!(rej_mode || quiet), quiet ? "R7" : "R2", "drive_cm unexpected", 1, 0);
      end
      if (release_o) begin
        chk(drv_run == DL, "R3", "drive cycles", drv_run, DL);
        drv_run  = 0;
        in_wait  = 1'b1;
        wait_run = 0;
      end else if (in_wait && !cmp_strobe) begin
        wait_run++;
      end
      if (cmp_strobe) begin
        chk(wait_run == exp_n, "R4", "wait cycles", wait_run, exp_n);
        in_wait = 1'b0;
      end
      if (done_o) begin
        if (q.size() == 0) chk(1'b0, "R7", "unexpected done", 1, 0);
        else begin
          e = q.pop_front();
          chk(cyc == e.at, e.tag, "done cycle", int'(cyc), int'(e.at));
          chk(status_o == e.code, "R6", "status code", status_o, e.code);
        end
      end else begin
        chk(status_o == 3'b000, "R6", "status while not done", status_o, 0);
      end
      // R5: the comparator shows the intended value only in the strobe cycle
      cmp_below = cmp_strobe ? exp_cmp : ~exp_cmp;
    end
  end

  task automatic run_req(input logic [1:0] ps, input logic [15:0] st,
                         input bit cv, input bit hold, input string tag);
    int n;
    exp_t x;
    n = (st == 16'd0) ? 1 : int'(st);
    @(negedge clk);
    pwr_state  = ps;
    settle_cnt = st;
    exp_cmp    = cv;
    exp_n      = n;
    rej_mode   = (ps != P1);
    x.at   = (ps == P1) ? cyc + DL + n + 3 : cyc + 1;
    x.code = (ps == P1 && cv) ? 3'b011 : 3'b000;
    x.tag  = tag;
    q.push_back(x);
    det_req = 1'b1;
    @(negedge clk);
    settle_cnt = ~st;             // R4: late change must not matter
    if (!hold) det_req = 1'b0;
    while (q.size() != 0) @(negedge clk);
    rej_mode = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!(drive_cm || release_o || cmp_strobe || done_o), "R8", "outputs in reset",
        {drive_cm, release_o, cmp_strobe, done_o}, 0);
    chk(status_o == 3'b000, "R8", "status in reset", status_o, 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);

    run_req(P1, 16'd10, 1'b1, 1'b0, "R1");
    run_req(P1, 16'd5,  1'b0, 1'b0, "R3");
    run_req(P1, 16'd0,  1'b1, 1'b0, "R4");
    run_req(P1, 16'd1,  1'b0, 1'b0, "R4");
    run_req(P1, 16'd7,  1'b1, 1'b0, "R5");
    run_req(2'b00, 16'd6, 1'b1, 1'b0, "R2");
    run_req(2'b10, 16'd2, 1'b1, 1'b0, "R2");
    run_req(2'b11, 16'd2, 1'b0, 1'b0, "R2");

    // R7: request held high does not retrigger
    run_req(P1, 16'd3, 1'b1, 1'b1, "R7");
    quiet = 1'b1;
    repeat (20) @(negedge clk);
    chk(q.size() == 0, "R7", "no extra completion", q.size(), 0);
    det_req = 1'b0;
    @(negedge clk);
    quiet = 1'b0;
    run_req(P1, 16'd2, 1'b0, 1'b0, "R7");

    // R8: reset in the middle of a sequence
    @(negedge clk);
    pwr_state = P1; settle_cnt = 16'd20; det_req = 1'b1;
    repeat (8) @(negedge clk);
    det_req = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    chk(!(drive_cm || release_o || cmp_strobe || done_o), "R8", "outputs after mid reset",
        {drive_cm, release_o, cmp_strobe, done_o}, 0);
    rst = 1'b0;
    drv_run = 0; in_wait = 1'b0;
    repeat (2) @(negedge clk);
    run_req(P1, 16'd4, 1'b1, 1'b0, "R8");

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule